// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller picks a 5-bit band code for a tunable oscillator. A larger code selects a lower frequency. A separate counter measures the frequency error once per reference period and reports it through a strobe, which carries a direction bit and two signed errors: the error for this period and the error for the period before. The controller first fixes the code by successive approximation, working from the top bit down. It then moves the code one step per period. On the first reversal of direction it stops and keeps whichever of the last two codes lies closer to the target. This final choice adds half a code step of effective resolution.

While the search runs, the hold output keeps the analog control voltage fixed. When the search finishes, hold drops and the done output rises. The code then stays where it is until the next start pulse. A test enable overrides the code with an external value and forces hold high for as long as it is asserted.

Top module: `cb_search_ctrl`

## Requirements
- R1: After reset, the code is 10000, hold is 0 and done is 0.
- R2: If test enable is low, a start pulse sets the code to 10000 and hold to 1 on the next cycle. A start pulse restarts the search from any state.
- R3: During the binary phase, each valid strobe taken at bit k (k runs from 4 down to 1) writes the direction bit into bit k and sets bit k-1 to 1. The strobe taken at bit 1 moves the controller to the stepping phase.
- R4: During the stepping phase, each valid strobe adds 1 to the code when the direction bit is 1 and subtracts 1 when it is 0.
- R5: If a stepping strobe has a direction bit that differs from the previous stepping strobe, the search ends. The errors are target minus measured. The gravity bit is the sign bit of (current error + previous error), and a zero sum counts as non-negative. Gravity 0 keeps the smaller of the current and previous codes; gravity 1 keeps the larger.
- R6: If a step would move the code below 00000 or above 11111, the search ends with the code left on that rail.
- R7: Once the search has ended, hold is 0 and done is 1. The code ignores valid strobes until the next start.
- R8: While test enable is high, the code output equals the test code, hold is 1 and done is 0, all in the same cycle. When test enable is released, the controller returns to idle with the code at 10000.
- R9: Valid strobes received while idle do not change the code, hold or done.
- R10: If the oscillator frequency falls monotonically as the code rises, the finished code is the one closest to the target. Ties go to the smaller code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that begins a new search |
| meas_valid_i | input | 1 | Strobe that marks one period's measurement |
| dir_up_i | input | 1 | 1 raises the code (frequency too high), 0 lowers it |
| err_cur_i | input | ERR_W | Signed error for this period, target minus measured |
| err_prev_i | input | ERR_W | Signed error for the previous period |
| test_en_i | input | 1 | Enables the forced-code test mode |
| test_code_i | input | CODE_W | Code applied while in test mode |
| code_o | output | CODE_W | Band code |
| hold_o | output | 1 | Holds the control voltage |
| done_o | output | 1 | Search has finished |

## Verification
Start and valid strobes are registered, so their effect on the code, hold and done appears one clock after the edge that samples them. Test enable drives the outputs combinationally and acts within the same cycle. The bench drives its inputs on the falling edge. It updates a behavioural model on the rising edge and compares every output one time unit after each falling edge, so each expected value lines up with the register delay. A frequency plant in the bench turns the code into the direction and error inputs, which lets the final code be checked against the nearest code worked out by exhaustive search.

// File: rtl/cb_search_pkg.sv
package cb_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BIN  = 3'd1,
    ST_LIN  = 3'd2,
    ST_DONE = 3'd3,
    ST_TEST = 3'd4
  } cb_state_e;
endpackage

// File: rtl/cb_bin_step.sv
module cb_bin_step #(
  parameter int CODE_W = 5,
  parameter int IDX_W  = $clog2(CODE_W)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              dir_i,
  output logic [CODE_W-1:0] code_o
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    always_comb begin
      if (idx_i == IDX_W'(i))          code_o[i] = dir_i;
      else if (idx_i == IDX_W'(i + 1)) code_o[i] = 1'b1;
      else                             code_o[i] = code_i[i];
    end
  end
endmodule

// File: rtl/cb_lin_step.sv
module cb_lin_step #(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              dir_i,
  output logic [CODE_W-1:0] code_o,
  output logic              rail_o
);
  always_comb begin
    rail_o = dir_i ? (&code_i) : ~(|code_i);
    code_o = dir_i ? code_i + CODE_W'(1) : code_i - CODE_W'(1);
  end
endmodule

// File: rtl/cb_pick.sv
module cb_pick #(
  parameter int CODE_W = 5,
  parameter int ERR_W  = 12
) (
  input  logic [CODE_W-1:0]       cur_i,
  input  logic [CODE_W-1:0]       prv_i,
  input  logic signed [ERR_W-1:0] err_a_i,
  input  logic signed [ERR_W-1:0] err_b_i,
  output logic [CODE_W-1:0]       pick_o
);
  logic signed [ERR_W:0] mass;
  logic                  gravity;
  logic [CODE_W-1:0]     lo, hi;

  always_comb begin
    mass    = {err_a_i[ERR_W-1], err_a_i} + {err_b_i[ERR_W-1], err_b_i};
    gravity = mass[ERR_W];
    lo      = (cur_i < prv_i) ? cur_i : prv_i;
    hi      = (cur_i < prv_i) ? prv_i : cur_i;
    pick_o  = gravity ? hi : lo;
  end

  // R5: result is always one of the two candidates
  always_comb assert_pick_member_R5: assert (pick_o == cur_i || pick_o == prv_i);
endmodule

// File: rtl/cb_search_ctrl.sv
module cb_search_ctrl
  import cb_search_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int ERR_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     meas_valid_i,
  input  logic                     dir_up_i,
  input  logic signed [ERR_W-1:0]  err_cur_i,
  input  logic signed [ERR_W-1:0]  err_prev_i,
  input  logic                     test_en_i,
  input  logic [CODE_W-1:0]        test_code_i,
  output logic [CODE_W-1:0]        code_o,
  output logic                     hold_o,
  output logic                     done_o
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] SEED = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);

  cb_state_e         st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d, prv_code_q, prv_code_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              prv_dir_q, prv_dir_d, has_prv_q, has_prv_d;
  logic [CODE_W-1:0] bin_nxt, lin_nxt, pick;
  logic              at_rail;

  cb_bin_step #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_bin (
    .code_i(code_q), .idx_i(idx_q), .dir_i(dir_up_i), .code_o(bin_nxt)
  );

  cb_lin_step #(.CODE_W(CODE_W)) u_lin (
    .code_i(code_q), .dir_i(dir_up_i), .code_o(lin_nxt), .rail_o(at_rail)
  );

  cb_pick #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_pick (
    .cur_i(code_q), .prv_i(prv_code_q), .err_a_i(err_cur_i), .err_b_i(err_prev_i),
    .pick_o(pick)
  );

  always_comb begin
    st_d       = st_q;
    code_d     = code_q;
    idx_d      = idx_q;
    prv_code_d = prv_code_q;
    prv_dir_d  = prv_dir_q;
    has_prv_d  = has_prv_q;
    if (test_en_i) begin
      st_d = ST_TEST;
    end else if (st_q == ST_TEST) begin
      st_d   = ST_IDLE;
      code_d = SEED;
    end else if (start_i) begin
      st_d      = ST_BIN;
      code_d    = SEED;
      idx_d     = TOP_IDX;
      has_prv_d = 1'b0;
    end else if (meas_valid_i) begin
      unique case (st_q)
        ST_BIN: begin
          code_d = bin_nxt;
          idx_d  = idx_q - IDX_W'(1);
          if (idx_q == IDX_W'(1)) begin
            st_d      = ST_LIN;
            has_prv_d = 1'b0;
          end
        end
        ST_LIN: begin
          if (has_prv_q && (dir_up_i != prv_dir_q)) begin
            code_d = pick;
            st_d   = ST_DONE;
          end else if (at_rail) begin
            st_d = ST_DONE;
          end else begin
            prv_code_d = code_q;
            prv_dir_d  = dir_up_i;
            has_prv_d  = 1'b1;
            code_d     = lin_nxt;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      code_q     <= SEED;
      idx_q      <= TOP_IDX;
      prv_code_q <= SEED;
      prv_dir_q  <= 1'b0;
      has_prv_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      code_q     <= code_d;
      idx_q      <= idx_d;
      prv_code_q <= prv_code_d;
      prv_dir_q  <= prv_dir_d;
      has_prv_q  <= has_prv_d;
    end
  end

  assign code_o = test_en_i ? test_code_i : code_q;
  assign hold_o = test_en_i | (st_q == ST_BIN) | (st_q == ST_LIN);
  assign done_o = ~test_en_i & (st_q == ST_DONE);

  assert_start_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !test_en_i && st_q != ST_TEST) |=> (code_q == SEED && st_q == ST_BIN));

  assert_bin_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIN && meas_valid_i && !start_i && !test_en_i) |=>
      ((code_q >> ($past(idx_q) + 1'b1)) == ($past(code_q) >> ($past(idx_q) + 1'b1)) &&
       code_q[$past(idx_q)] == $past(dir_up_i)));

  assert_lin_unit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LIN && meas_valid_i && !start_i && !test_en_i) |=>
      (st_q == ST_DONE || code_q == $past(code_q) + CODE_W'(1) ||
       code_q == $past(code_q) - CODE_W'(1)));

  assert_done_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !start_i && !test_en_i) |=> $stable(code_q));

  assert_test_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i |-> (hold_o && !done_o));
endmodule

// File: tb/cb_search_ctrl_test.sv
module cb_search_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, dir = 1'b0, test_en = 1'b0;
  logic signed [11:0] ecur = '0, eprv = '0;
  logic [4:0] tcode = '0;
  logic [4:0] code;
  logic hold, done;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // behavioural reference model
  int m_st = 0, m_code = 16, m_idx = 4, m_pcode = 16, m_nxt, m_sum;
  bit m_pdir = 0, m_hasp = 0;

  cb_search_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .meas_valid_i(valid),
    .dir_up_i(dir), .err_cur_i(ecur), .err_prev_i(eprv), .test_en_i(test_en),
    .test_code_i(tcode), .code_o(code), .hold_o(hold), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_code = 16; m_idx = 4; m_hasp = 0;
    end else if (test_en) m_st = 4;
    else if (m_st == 4) begin m_st = 0; m_code = 16; end
    else if (start) begin m_st = 1; m_code = 16; m_idx = 4; m_hasp = 0; end
    else if (valid) begin
      if (m_st == 1) begin
        if (!dir) m_code = m_code - (1 << m_idx);
        m_code = m_code + (1 << (m_idx - 1));
        if (m_idx == 1) begin m_st = 2; m_hasp = 0; end
        m_idx = m_idx - 1;
      end else if (m_st == 2) begin
        m_nxt = dir ? m_code + 1 : m_code - 1;
        if (m_hasp && dir != m_pdir) begin
          m_sum = int'(ecur) + int'(eprv);
          if (m_sum < 0) m_code = (m_code > m_pcode) ? m_code : m_pcode;
          else           m_code = (m_code < m_pcode) ? m_code : m_pcode;
          m_st = 3;
        end else if (m_nxt < 0 || m_nxt > 31) m_st = 3;
        else begin m_pcode = m_code; m_pdir = dir; m_hasp = 1; m_code = m_nxt; end
      end
    end
  end

  function automatic string tag_of(int st);
    case (st)
      0: return "R1/R9";
      1: return "R2/R3";
      2: return "R4/R5/R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // compare every cycle, one time unit after the falling edge
  always @(negedge clk) begin
    int e_code; bit e_hold, e_done;
    #1;
    cyc++;
    e_code = test_en ? int'(tcode) : m_code;
    e_hold = test_en || m_st == 1 || m_st == 2;
    e_done = !test_en && m_st == 3;
    n_cmp++;
    if (int'(code) != e_code || hold != e_hold || done != e_done) begin
      n_bad++;
      $display("FAIL %s cyc=%0d code/hold/done actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
               tag_of(m_st), cyc, code, hold, done, e_code, e_hold, e_done);
    end
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int freq(int c); return 1000 - 10 * c; endfunction
  function automatic int absi(int v); return v < 0 ? -v : v; endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // plant: one measurement every 4 cycles from the current code
  task automatic run_plant(input int tgt, input int periods);
    int last_err = 0;
    for (int p = 0; p < periods; p++) begin
      int err;
      @(negedge clk);
      if (done) break;
      err   = tgt - freq(int'(code));
      dir   = (err < 0);
      ecur  = 12'(err);
      eprv  = 12'(last_err);
      valid = 1'b1;
      last_err = err;
      @(negedge clk); valid = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic check_closest(input int tgt);
    int best = 0;
    for (int c = 1; c < 32; c++)
      if (absi(tgt - freq(c)) < absi(tgt - freq(best))) best = c;
    #2;
    n_cmp++;
    if (int'(code) != best || !done) begin
      n_bad++;
      $display("FAIL R10 target=%0d actual=%0d done=%0b expected=%0d", tgt, code, done, best);
    end
  endtask

  task automatic search(input int tgt);
    pulse_start();
    run_plant(tgt, 16);
    check_closest(tgt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: idle strobes ignored
    repeat (3) begin @(negedge clk); valid = 1'b1; dir = 1'b1; @(negedge clk); valid = 1'b0; end
    search(838);
    // R7: strobes after done ignored
    repeat (3) begin @(negedge clk); valid = 1'b1; dir = ~dir; @(negedge clk); valid = 1'b0; end
    search(797);
    search(1004);   // R6 lower rail
    search(683);    // R6 upper rail
    search(903);    // R5 gravity picks larger
    search(846);
    // R2: restart mid-search
    pulse_start();
    run_plant(838, 2);
    search(797);
    // R8: forced code
    @(negedge clk); test_en = 1'b1; tcode = 5'b10101;
    repeat (3) @(negedge clk);
    valid = 1'b1; start = 1'b1; @(negedge clk); valid = 1'b0; start = 1'b0;
    tcode = 5'b00011;
    repeat (2) @(negedge clk);
    test_en = 1'b0;
    repeat (3) @(negedge clk);
    pulse_start();
    run_plant(760, 2);
    @(negedge clk); test_en = 1'b1; tcode = 5'b11100;
    repeat (3) @(negedge clk); test_en = 1'b0;
    search(683);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule